// File: doc/BRIEF.md
# Vector Register Element Load/Store Sequencer

This block moves one 64-bit short-vector register between the core and a narrow memory port that carries either one 16-bit halfword or one 32-bit word per access. A request gives an opcode, an effective address, the 64-bit store value and an endian flag. The sequencer then issues the halfword or word accesses that the opcode calls for, at fixed offsets from the effective address.

On loads it builds the 64-bit result. Depending on the opcode, each lane is filled from memory, cleared to zero, sign-extended, or filled with a copy of another lane. On stores it cuts the register into the memory elements that the opcode selects.

In little-endian mode the bytes inside each element are reversed, element by element. Element addresses and lane positions do not change. Requests are accepted with a start strobe, and completion is reported with a one-cycle done pulse.

Top module: `simd_ls_seq`

## Requirements
- R1: Opcode 0 (four-halfword load) reads halfwords at EA, EA+2, EA+4 and EA+6 and places them in ld_data bits 63:48, 47:32, 31:16 and 15:0 respectively; a halfword read is taken from mem_rdata bits 15:0.
- R2: Opcode 1 (two-word load) places the word at EA in bits 63:32 and the word at EA+4 in bits 31:0. Opcode 9 (two-word store) writes bits 63:32 to EA and bits 31:0 to EA+4.
- R3: Opcode 2 (even-halfword load) puts the halfword at EA in bits 63:48 and the halfword at EA+2 in bits 31:16, and clears every other bit. Opcode 10 (even store) writes bits 63:48 to EA and bits 31:16 to EA+2.
- R4: Opcodes 3 and 4 (odd-halfword loads) put the halfword at EA in bits 47:32 and the halfword at EA+2 in bits 15:0. Opcode 3 fills the upper 16 bits of each word with zeros. Opcode 4 fills them with copies of the halfword's bit 15. Opcode 11 (odd store) writes bits 47:32 to EA and bits 15:0 to EA+2.
- R5: The splat loads work as follows. Opcode 5 reads one halfword at EA into bits 63:48 and 31:16 and clears the rest. Opcode 6 reads one word at EA into both 32-bit halves. Opcode 7 copies the halfword at EA into bits 63:48 and 47:32, and the halfword at EA+2 into bits 31:16 and 15:0.
- R6: Opcode 12 (low-word store) makes exactly one word write, bits 31:0 to EA. Opcode 8 (four-halfword store) writes bits 63:48, 47:32, 31:16 and 15:0 to EA, EA+2, EA+4 and EA+6.
- R7: When le is 1, each element has its bytes reversed on its own. Addresses, lane positions and access sizes are the same as with le at 0. A halfword write drives mem_wdata bits 15:0 and zeros in bits 31:16. mem_word is 1 for a word access and 0 for a halfword access.
- R8: Accesses go out one at a time in ascending address order. mem_req, mem_addr, mem_we and mem_wdata stay stable until mem_ack, and the next access starts only after that acknowledge.
- R9: done is high for exactly one cycle, in the cycle after the final mem_ack. ld_data holds the load result from that cycle until the next accepted request.
- R10: Opcodes 13 to 15 raise done together with err in the cycle after start and issue no memory access.
- R11: start is ignored while busy is high; the request in progress completes unchanged.
- R12: After reset, busy, done, err, mem_req and ld_data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken while idle |
| op | input | 4 | Opcode |
| ea | input | ADDR_W | Effective address |
| st_data | input | 64 | Register value for stores |
| le | input | 1 | Little-endian element mode |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unrecognised opcode, with done |
| ld_data | output | 64 | Assembled load result |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_word | output | 1 | 1 = word access, 0 = halfword access |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access acknowledge |

## Verification
The bench builds the block with the default 32-bit address width. It keeps effective addresses below 2^31, so the largest offset, EA+6, never wraps, and ascending order can be checked directly. The bench's memory answers each access after a random wait of zero to two cycles, which exercises both back-to-back acknowledges and held requests. It also puts junk in the unused upper half of every halfword read, so a design that uses those bits is caught.

// File: rtl/simd_ls_seq.sv
module simd_ls_seq #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        op,
  input  logic [ADDR_W-1:0] ea,
  input  logic [63:0]       st_data,
  input  logic              le,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [63:0]       ld_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_word,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack
);

  localparam logic [3:0] OP_LH4   = 4'd0;
  localparam logic [3:0] OP_LW2   = 4'd1;
  localparam logic [3:0] OP_LHE   = 4'd2;
  localparam logic [3:0] OP_LHOU  = 4'd3;
  localparam logic [3:0] OP_LHOS  = 4'd4;
  localparam logic [3:0] OP_LHSPL = 4'd5;
  localparam logic [3:0] OP_LWSPL = 4'd6;
  localparam logic [3:0] OP_LHPR  = 4'd7;
  localparam logic [3:0] OP_SH4   = 4'd8;
  localparam logic [3:0] OP_SW2   = 4'd9;
  localparam logic [3:0] OP_SHE   = 4'd10;
  localparam logic [3:0] OP_SHO   = 4'd11;
  localparam logic [3:0] OP_SWLO  = 4'd12;

  function automatic logic [15:0] bswap16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  function automatic logic [31:0] bswap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  logic              busy_q, done_q, err_q, le_q;
  logic [1:0]        idx_q;
  logic [3:0]        op_q;
  logic [ADDR_W-1:0] ea_q;
  logic [63:0]       sd_q, acc_q, acc_nx;
  logic [2:0]        n_acc;
  logic              is_word, is_store, last_acc;
  logic [15:0]       st_h, rd_h;
  logic [31:0]       st_w, rd_w;

  always_comb begin
    n_acc   = 3'd1;
    is_word = 1'b0;
    case (op_q)
      OP_LH4, OP_SH4:                                   n_acc = 3'd4;
      OP_LW2, OP_SW2:                    begin n_acc = 3'd2; is_word = 1'b1; end
      OP_LHE, OP_LHOU, OP_LHOS, OP_LHPR,
      OP_SHE, OP_SHO:                                   n_acc = 3'd2;
      OP_LWSPL, OP_SWLO:                 begin n_acc = 3'd1; is_word = 1'b1; end
      default:                                          n_acc = 3'd1;
    endcase
  end

  assign is_store = op_q[3];
  assign last_acc = ({1'b0, idx_q} == n_acc - 3'd1);

  always_comb begin
    st_h = 16'h0;
    st_w = 32'h0;
    case (op_q)
      OP_SH4:  st_h = sd_q[63 - 16*int'(idx_q) -: 16];
      OP_SW2:  st_w = idx_q[0] ? sd_q[31:0]  : sd_q[63:32];
      OP_SHE:  st_h = idx_q[0] ? sd_q[31:16] : sd_q[63:48];
      OP_SHO:  st_h = idx_q[0] ? sd_q[15:0]  : sd_q[47:32];
      OP_SWLO: st_w = sd_q[31:0];
      default: ;
    endcase
  end

  assign rd_h = le_q ? bswap16(mem_rdata[15:0]) : mem_rdata[15:0];
  assign rd_w = le_q ? bswap32(mem_rdata)       : mem_rdata;

  always_comb begin
    acc_nx = acc_q;
    case (op_q)
      OP_LH4:   acc_nx[63 - 16*int'(idx_q) -: 16] = rd_h;
      OP_LW2:   if (idx_q[0]) acc_nx[31:0] = rd_w; else acc_nx[63:32] = rd_w;
      OP_LHE:   if (idx_q[0]) acc_nx[31:16] = rd_h; else acc_nx[63:48] = rd_h;
      OP_LHOU:  if (idx_q[0]) acc_nx[31:0] = {16'h0, rd_h};
                else          acc_nx[63:32] = {16'h0, rd_h};
      OP_LHOS:  if (idx_q[0]) acc_nx[31:0] = {{16{rd_h[15]}}, rd_h};
                else          acc_nx[63:32] = {{16{rd_h[15]}}, rd_h};
      OP_LHSPL: acc_nx = {rd_h, 16'h0, rd_h, 16'h0};
      OP_LWSPL: acc_nx = {rd_w, rd_w};
      OP_LHPR:  if (idx_q[0]) acc_nx[31:0] = {rd_h, rd_h};
                else          acc_nx[63:32] = {rd_h, rd_h};
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      le_q   <= 1'b0;
      idx_q  <= 2'd0;
      op_q   <= 4'd0;
      ea_q   <= '0;
      sd_q   <= 64'h0;
      acc_q  <= 64'h0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          if (op > OP_SWLO) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            busy_q <= 1'b1;
            op_q   <= op;
            ea_q   <= ea;
            sd_q   <= st_data;
            le_q   <= le;
            idx_q  <= 2'd0;
            acc_q  <= 64'h0;
          end
        end
      end else if (mem_ack) begin
        if (!is_store) acc_q <= acc_nx;
        if (last_acc) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 2'd1;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign err       = err_q;
  assign ld_data   = acc_q;
  assign mem_req   = busy_q;
  assign mem_we    = is_store;
  assign mem_word  = is_word;
  assign mem_addr  = ea_q + ADDR_W'(is_word ? {1'b0, idx_q, 2'b00} : {2'b00, idx_q, 1'b0});
  assign mem_wdata = is_word ? (le_q ? bswap32(st_w) : st_w)
                             : {16'h0, (le_q ? bswap16(st_h) : st_h)};

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)); // R8
  AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $past(mem_req) && $past(mem_ack) |-> mem_addr > $past(mem_addr)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> $past(mem_ack) && !mem_req); // R9
  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && !mem_req && !$past(mem_req)); // R10
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !mem_word |-> mem_wdata[31:16] == 16'h0); // R7

endmodule

// File: tb/simd_ls_seq_test.sv
module simd_ls_seq_test;
  localparam int AW = 32;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          start = 1'b0, le = 1'b0;
  logic [3:0]    op = 4'd0;
  logic [AW-1:0] ea = '0;
  logic [63:0]   st_data = 64'h0;
  logic          busy, done, err, mem_req, mem_we, mem_word, mem_ack;
  logic [63:0]   ld_data;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;

  simd_ls_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .ea(ea), .st_data(st_data),
    .le(le), .busy(busy), .done(done), .err(err), .ld_data(ld_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, ack_cyc = 0, ln = 0, wcnt = 0;
  logic [AW-1:0] l_addr [8];
  logic          l_word [8];
  logic          l_we   [8];
  logic [31:0]   l_data [8];
  int            e_n;
  logic [AW-1:0] e_addr [4];
  logic          e_word [4];
  logic [31:0]   e_data [4];
  bit            finished = 0;

  function automatic logic [7:0] mb(input logic [AW-1:0] a);
    return (a[7:0] * 8'd37 + a[15:8]) ^ 8'hA5;
  endfunction

  function automatic logic [15:0] eh(input logic [AW-1:0] a, input logic l);
    return l ? {mb(a+1), mb(a)} : {mb(a), mb(a+1)};
  endfunction

  function automatic logic [31:0] ew(input logic [AW-1:0] a, input logic l);
    return l ? {mb(a+3), mb(a+2), mb(a+1), mb(a)} : {mb(a), mb(a+1), mb(a+2), mb(a+3)};
  endfunction

  function automatic logic [15:0] s16(input logic [15:0] v, input logic l);
    return l ? {v[7:0], v[15:8]} : v;
  endfunction

  function automatic logic [31:0] s32(input logic [31:0] v, input logic l);
    return l ? {v[7:0], v[15:8], v[23:16], v[31:24]} : v;
  endfunction

  function automatic logic [63:0] exp_load(input logic [3:0] o, input logic [AW-1:0] a, input logic l);
    logic [15:0] h0, h1;
    h0 = eh(a, l); h1 = eh(a+2, l);
    case (o)
      4'd0: return {h0, h1, eh(a+4, l), eh(a+6, l)};
      4'd1: return {ew(a, l), ew(a+4, l)};
      4'd2: return {h0, 16'h0, h1, 16'h0};
      4'd3: return {16'h0, h0, 16'h0, h1};
      4'd4: return {{16{h0[15]}}, h0, {16{h1[15]}}, h1};
      4'd5: return {h0, 16'h0, h0, 16'h0};
      4'd6: return {ew(a, l), ew(a, l)};
      4'd7: return {h0, h0, h1, h1};
      default: return 64'h0;
    endcase
  endfunction

  task automatic push(input logic [AW-1:0] a, input logic w, input logic [31:0] d);
    e_addr[e_n] = a; e_word[e_n] = w; e_data[e_n] = d; e_n++;
  endtask

  task automatic build_exp(input logic [3:0] o, input logic [AW-1:0] a, input logic [63:0] d, input logic l);
    e_n = 0;
    case (o)
      4'd0, 4'd8: for (int k = 0; k < 4; k++)
                    push(a + 2*k, 1'b0, (o == 4'd8) ? {16'h0, s16(d[63-16*k -: 16], l)} : 32'h0);
      4'd1: begin push(a, 1'b1, 32'h0); push(a+4, 1'b1, 32'h0); end
      4'd9: begin push(a, 1'b1, s32(d[63:32], l)); push(a+4, 1'b1, s32(d[31:0], l)); end
      4'd2, 4'd3, 4'd4, 4'd7: begin push(a, 1'b0, 32'h0); push(a+2, 1'b0, 32'h0); end
      4'd5: push(a, 1'b0, 32'h0);
      4'd6: push(a, 1'b1, 32'h0);
      4'd10: begin push(a, 1'b0, {16'h0, s16(d[63:48], l)}); push(a+2, 1'b0, {16'h0, s16(d[31:16], l)}); end
      4'd11: begin push(a, 1'b0, {16'h0, s16(d[47:32], l)}); push(a+2, 1'b0, {16'h0, s16(d[15:0], l)}); end
      4'd12: push(a, 1'b1, s32(d[31:0], l));
      default: ;
    endcase
  endtask

  function automatic string tag(input logic [3:0] o, input logic l);
    string t;
    case (o)
      4'd0:               t = "R1";
      4'd1, 4'd9:         t = "R2";
      4'd2, 4'd10:        t = "R3";
      4'd3, 4'd4, 4'd11:  t = "R4";
      4'd5, 4'd6, 4'd7:   t = "R5";
      4'd8, 4'd12:        t = "R6";
      default:            t = "R10";
    endcase
    return l ? {t, "/R7"} : t;
  endfunction

  task automatic chk(input bit ok, input string t, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial begin
    mem_ack = 1'b0;
    mem_rdata = 32'h0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (wcnt != 0) wcnt--;
        else begin
          mem_ack = 1'b1;
          mem_rdata = mem_word ? {mb(mem_addr), mb(mem_addr+1), mb(mem_addr+2), mb(mem_addr+3)}
                               : {16'hDEAD, mb(mem_addr), mb(mem_addr+1)};
          if (ln < 8) begin
            l_addr[ln] = mem_addr; l_word[ln] = mem_word;
            l_we[ln] = mem_we; l_data[ln] = mem_wdata;
          end
          ln++;
          ack_cyc = cyc;
          wcnt = $urandom % 3;
        end
      end
    end
  end

  task automatic run(input logic [3:0] o, input logic [AW-1:0] a, input logic [63:0] d,
                     input logic l, input bit poke);
    int t;
    bit ok;
    string tg;
    tg = tag(o, l);
    @(negedge clk);
    ln = 0; start = 1'b1; op = o; ea = a; st_data = d; le = l;
    @(negedge clk);
    if (poke) begin
      op = 4'hF; ea = a + 100; st_data = ~d; le = ~l;
      @(negedge clk);
    end
    start = 1'b0;
    t = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    if (!done) begin
      chk(1'b0, tg, "watchdog waiting for done", 64'(t), 64'd200);
      return;
    end
    if (o > 4'd12) begin
      chk(err && ln == 0, "R10", "err with no access", {err, 31'h0, 32'(ln)}, {1'b1, 63'h0});
    end else begin
      build_exp(o, a, d, l);
      ok = (ln == e_n) && !err;
      for (int k = 0; k < 4; k++)
        if (k < e_n && k < ln)
          ok = ok && l_addr[k] == e_addr[k] && l_word[k] == e_word[k] && l_we[k] == o[3]
                  && (!o[3] || l_data[k] == e_data[k]);
      chk(ok, poke ? {tg, "/R11/R8"} : {tg, "/R8"}, "access list",
          {32'(ln), l_addr[0]}, {32'(e_n), e_addr[0]});
      if (!o[3]) chk(ld_data == exp_load(o, a, l), poke ? {tg, "/R11"} : tg, "load data",
                     ld_data, exp_load(o, a, l));
      chk(cyc == ack_cyc + 1, "R9", "done one cycle after last ack", 64'(cyc), 64'(ack_cyc + 1));
    end
    @(negedge clk);
    chk(!done && !err && !busy, "R9", "done single pulse", {done, err, busy}, 64'h0);
    if (!o[3] && o <= 4'd12)
      chk(ld_data == exp_load(o, a, l), tg, "load data held", ld_data, exp_load(o, a, l));
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !mem_req && ld_data == 64'h0, "R12", "reset state",
        {busy, done, err, mem_req, 60'h0} | ld_data, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed: every opcode in both endian modes
    for (int o = 0; o < 16; o++) begin
      run(4'(o), 32'h0000_1230, 64'h8899_AABB_CCDD_EEFF, 1'b0, 1'b0);
      run(4'(o), 32'h0000_4F80, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b0);
    end
    // sign-extension corner: negative and positive halfwords
    run(4'd4, 32'h0000_00F0, 64'h0, 1'b0, 1'b0);
    run(4'd4, 32'h0000_0010, 64'h0, 1'b1, 1'b0);
    // start held while busy must be ignored (R11)
    run(4'd0, 32'h0000_2000, 64'h0, 1'b0, 1'b1);
    run(4'd8, 32'h0000_3000, 64'hFEDC_BA98_7654_3210, 1'b1, 1'b1);
    // constrained random
    for (int n = 0; n < 300; n++)
      run(4'($urandom % 16), AW'($urandom % 32'h8000_0000),
          {$urandom, $urandom}, 1'($urandom % 2), 1'b0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule